// File: doc/BRIEF.md
# SHA-256 Message Schedule Update Unit (sigma-1 half)

This block performs the second half of one SHA-256 message-schedule expansion step. It produces four new 32-bit schedule words at once from three 128-bit operands of four 32-bit lanes each. The operands are:

- an accumulator operand that carries the partial sums left by the first (sigma-0) half;
- a "previous" operand;
- a "late" operand holding the most recent schedule words.

Every output lane is the sum, modulo 2^32, of three terms: the small sigma-1 function of a selected word, one accumulator lane, and one lane of a 128-bit value spliced from the previous and late operands. The two upper output lanes do not use operand words for their sigma-1 input. They take sigma-1 of the two lower output lanes computed in the same cycle, so the whole chain settles combinationally in one clock.

The interface has no back-pressure. A one-cycle `in_valid` strobe samples the operands. The result and `out_valid` are registered and appear on the next clock edge. A new operand set may be presented on every cycle, and the block never stalls. There are no status or flag outputs.

Top module: `msg_sched_upd`

## Requirements
- R1: sigma1(x) = rotr(x,17) XOR rotr(x,19) XOR (x >> 10), on 32-bit words. Lane k of any 128-bit value occupies bits 32k+31 down to 32k.
- R2: Output lanes 0 and 1 are built as follows. Lane 0 = sigma1(late lane 2) + acc lane 0 + prev lane 1. Lane 1 = sigma1(late lane 3) + acc lane 1 + prev lane 2.
- R3: Output lanes 2 and 3 apply sigma1 to output lanes 0 and 1 of the same operation, not to operand words. Lane 2 = sigma1(out lane 0) + acc lane 2 + prev lane 3. Lane 3 = sigma1(out lane 1) + acc lane 3 + late lane 0.
- R4: The spliced addend is built from late bits 31:0 on top of prev bits 127:32. Its lane 3 is therefore late lane 0, and its lanes 0 to 2 are prev lanes 1 to 3.
- R5: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `result` carries that operation's value.
- R6: When `in_valid` is low at a rising edge, `out_valid` is low after it and `result` keeps its previous value whatever the operand inputs hold.
- R7: A synchronous active-high `rst` clears `out_valid` and `result` to zero.
- R8: Operand sets presented on consecutive cycles each produce their own correct result on consecutive cycles, with no gap.
- R9: All additions wrap modulo 2^32 per lane, and no carry crosses a lane boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Samples the three operands this cycle |
| acc_in | input | 128 | Accumulator operand (partial schedule sums) |
| prev_in | input | 128 | Previous schedule words operand |
| late_in | input | 128 | Most recent schedule words operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 128 | Four new schedule words |

## Verification
The block holds only the result register and one valid flag, so any corruption shows at the ports on the edge after the operation it concerns. A wrong lane-select or splice corrupts the matching lane directly. A fault in the lower lanes also propagates, through sigma-1, into the upper lanes of that same result. This is why the bench compares all four lanes against an independent model and also runs a known vector from a real message expansion. A broken hold or valid path shows as a changed `result` or a stray `out_valid` on the first idle cycle.

// File: rtl/msg_sched_pkg.sv
package msg_sched_pkg;
  parameter int LW = 32;
  parameter int NL = 4;
  localparam int VW = LW * NL;
  localparam int HALF = NL / 2;
  localparam int ROT_A = 17;
  localparam int ROT_B = 19;
  localparam int SHR_C = 10;

  function automatic logic [LW-1:0] small_sig1(input logic [LW-1:0] x);
    return ((x >> ROT_A) | (x << (LW - ROT_A))) ^
           ((x >> ROT_B) | (x << (LW - ROT_B))) ^
           (x >> SHR_C);
  endfunction
endpackage

// File: rtl/sched_sigma1.sv
module sched_sigma1
  import msg_sched_pkg::*;
(
  input  logic [LW-1:0] word_i,
  output logic [LW-1:0] word_o
);
  logic [LW-1:0] rot_a, rot_b, shr_c;

  assign rot_a  = {word_i[ROT_A-1:0], word_i[LW-1:ROT_A]};
  assign rot_b  = {word_i[ROT_B-1:0], word_i[LW-1:ROT_B]};
  assign shr_c  = word_i >> SHR_C;
  assign word_o = rot_a ^ rot_b ^ shr_c;
endmodule

// File: rtl/sched_lane_add.sv
module sched_lane_add
  import msg_sched_pkg::*;
(
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  input  logic [LW-1:0] c_i,
  output logic [LW-1:0] sum_o
);
  // Wrapping per-lane add; carries out of the lane are dropped.
  assign sum_o = a_i + b_i + c_i;
endmodule

// File: rtl/msg_sched_upd.sv
module msg_sched_upd
  import msg_sched_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [VW-1:0] acc_in,
  input  logic [VW-1:0] prev_in,
  input  logic [VW-1:0] late_in,
  output logic          out_valid,
  output logic [VW-1:0] result
);
  localparam int HW = VW / 2;

  logic [VW-1:0] splice;
  logic [HW-1:0] lo_flat;
  logic [HW-1:0] hi_flat;

  // Third addend: late lane 0 on top, prev lanes 3..1 below.
  assign splice = {late_in[LW-1:0], prev_in[VW-1:LW]};

  // Lower lanes: sigma-1 of the late operand's upper half.
  for (genvar i = 0; i < HALF; i++) begin : g_lo
    logic [LW-1:0] sig_out;
    sched_sigma1 u_sig (
      .word_i(late_in[HW + i*LW +: LW]),
      .word_o(sig_out)
    );
    sched_lane_add u_add (
      .a_i  (sig_out),
      .b_i  (acc_in[i*LW +: LW]),
      .c_i  (splice[i*LW +: LW]),
      .sum_o(lo_flat[i*LW +: LW])
    );
  end

  // Upper lanes: sigma-1 of the freshly computed lower lanes (same cycle).
  for (genvar j = 0; j < HALF; j++) begin : g_hi
    logic [LW-1:0] sig_out;
    sched_sigma1 u_sig (
      .word_i(lo_flat[j*LW +: LW]),
      .word_o(sig_out)
    );
    sched_lane_add u_add (
      .a_i  (sig_out),
      .b_i  (acc_in[HW + j*LW +: LW]),
      .c_i  (splice[HW + j*LW +: LW]),
      .sum_o(hi_flat[j*LW +: LW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= {hi_flat, lo_flat};
    end
  end
endmodule

// File: rtl/msg_sched_upd_chk.sv
module msg_sched_upd_chk
  import msg_sched_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [VW-1:0] acc_in,
  input logic [VW-1:0] prev_in,
  input logic [VW-1:0] late_in,
  input logic          out_valid,
  input logic [VW-1:0] result
);
  a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  a_r7_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  a_r2_lane0: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> result[LW-1:0] ==
      $past(small_sig1(late_in[2*LW +: LW]) + acc_in[0 +: LW] + prev_in[LW +: LW]));

  a_r3_lane2_chain: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> result[2*LW +: LW] ==
      small_sig1(result[0 +: LW]) + $past(acc_in[2*LW +: LW] + prev_in[3*LW +: LW]));

  a_r4_lane3_splice: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> result[3*LW +: LW] ==
      small_sig1(result[LW +: LW]) + $past(acc_in[3*LW +: LW] + late_in[0 +: LW]));
endmodule

bind msg_sched_upd msg_sched_upd_chk u_chk (.*);

// File: tb/msg_sched_upd_test.sv
module msg_sched_upd_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] acc_in = '0, prev_in = '0, late_in = '0;
  logic         out_valid;
  logic [127:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  msg_sched_upd uut (.*);

  function automatic logic [31:0] s1(input logic [31:0] w);
    logic [63:0] d;
    d = {w, w};
    return d[48:17] ^ d[50:19] ^ {10'd0, w[31:10]};
  endfunction

  function automatic logic [127:0] model(input logic [127:0] a, p, l);
    logic [31:0] r0, r1, r2, r3;
    r0 = s1(l[95:64])  + a[31:0]   + p[63:32];
    r1 = s1(l[127:96]) + a[63:32]  + p[95:64];
    r2 = s1(r0)        + a[95:64]  + p[127:96];
    r3 = s1(r1)        + a[127:96] + l[31:0];
    return {r3, r2, r1, r0};
  endfunction

  task automatic check(input string req, input logic [127:0] act, exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // acc, prev, late, expected
  localparam logic [511:0] VECS [3] = '{
    {128'h0, 128'h0, 128'h0, 128'h0},
    // R9 wrap: lanes 0/1 = all ones, lanes 2/3 = s1(all ones)+all ones
    {128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 128'h0, 128'h0,
     128'h003FFFFE_003FFFFE_FFFFFFFF_FFFFFFFF},
    // Message "abc": W[16..19] of its expansion
    {128'h00000000_00000000_00000000_61626380, 128'h0,
     128'h00000018_00000000_00000000_00000000,
     128'h600003c6_7da86405_000f0000_61626380}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [127:0] exp_q, held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R7 reset valid", {127'd0, out_valid}, 128'd0);
    check("R7 reset result", result, 128'd0);

    // Table walk: R2 R3 R4 R5 R9
    for (int k = 0; k < 3; k++) begin
      {acc_in, prev_in, late_in, exp_q} = VECS[k];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R5 out_valid", {127'd0, out_valid}, 128'd1);
      check("R2/R3/R4 table result", result, exp_q);
      @(negedge clk);
    end

    // R8 back-to-back random stream against the model (R1 R2 R3 R4)
    exp_q = '0;
    for (int k = 0; k <= 24; k++) begin
      if (k > 0) begin
        check("R8 stream valid", {127'd0, out_valid}, 128'd1);
        check("R1 R2 R3 R4 stream result", result, exp_q);
      end
      if (k < 24) begin
        acc_in  = {$urandom, $urandom, $urandom, $urandom};
        prev_in = {$urandom, $urandom, $urandom, $urandom};
        late_in = {$urandom, $urandom, $urandom, $urandom};
        in_valid = 1'b1;
        exp_q = model(acc_in, prev_in, late_in);
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end

    // R6: idle cycles with changing operands leave result untouched
    held = result;
    check("R6 idle valid", {127'd0, out_valid}, 128'd0);
    for (int k = 0; k < 4; k++) begin
      acc_in = {4{$urandom}};
      late_in = {4{$urandom}};
      @(negedge clk);
      check("R6 hold result", result, held);
      check("R6 idle valid", {127'd0, out_valid}, 128'd0);
    end

    // R7: reset while a valid operation is presented
    acc_in = {4{32'h1234_5678}};
    in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R7 mid reset valid", {127'd0, out_valid}, 128'd0);
    check("R7 mid reset result", result, 128'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule